// File: doc/BRIEF.md
# Narrow-Write Lane Replicator and Word Bridge

This block takes one write from a DMA-style requester and prepares it for a slave that has no notion of transfer size. On the AHB-style side, the narrow datum is copied into every lane of the 32-bit write data bus. A byte fills all four byte lanes and a halfword fills both halves. The original size code is driven next to the replicated data.

The same block also acts as a bridge that ignores the size code. Every write leaves it as one full-word APB write. The address is rounded down to the word boundary, all byte strobes are raised, and the data is the replicated word. As a result, a slave that only understands words receives the narrow value repeated across the whole word.

A write is accepted in its address phase while the ready output is high. The datum is taken from the following data phase. The block then runs one APB setup phase and one or more access phases. It holds ready low until the APB slave signals completion.

Top module: `narrow_wr_bridge`

## Requirements
- R1: During and right after reset, `ahb_ready` is 1, and `apb_sel`, `apb_enable` and `apb_strb` are 0.
- R2: Size code 0 means byte. `apb_wdata` and `ahb_wdata` carry `wr_datum[7:0]` in all four byte lanes, and `ahb_size` reads 0.
- R3: Size code 1 means halfword. `apb_wdata` and `ahb_wdata` carry `wr_datum[15:0]` in both halves, and `ahb_size` reads 1.
- R4: Size codes 2 to 7 pass the full 32-bit datum through unchanged, and `ahb_size` echoes the code.
- R5: `apb_addr` equals the accepted write address with bits [1:0] cleared, for any value of those two bits.
- R6: Whenever `apb_sel` is 1, `apb_write` is 1 and `apb_strb` is 4'hF.
- R7: A request seen with `wr_req`=1 and `ahb_ready`=1 at a rising edge is accepted. The datum is sampled at the next edge, and later changes of `wr_datum` are ignored. The cycle after sampling is the setup phase (`apb_sel`=1, `apb_enable`=0). The cycle after that is the access phase (both 1).
- R8: While `apb_ready` is 0 in the access phase, the access phase is held with `apb_addr` and `apb_wdata` stable. `ahb_ready` is 0 from acceptance until the edge at which `apb_ready` is 1 in the access phase, and it is 1 in the cycle after that edge.
- R9: `wr_req`, `wr_addr` and `wr_size` are ignored while `ahb_ready` is 0. No extra APB transfer results, and the address and size already captured are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Write request in address phase |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | 3 | Size code: 0 byte, 1 halfword, 2 and above word |
| wr_datum | input | DATA_W | Narrow datum in the low bits, valid in data phase |
| ahb_ready | output | 1 | High when a new request can be accepted |
| ahb_wdata | output | DATA_W | Replicated write data |
| ahb_size | output | 3 | Size code of the write in flight |
| apb_addr | output | ADDR_W | Word-aligned APB address |
| apb_sel | output | 1 | APB select |
| apb_enable | output | 1 | APB enable, access phase |
| apb_write | output | 1 | APB write direction |
| apb_wdata | output | DATA_W | APB write data, replicated word |
| apb_strb | output | DATA_W/8 | APB byte strobes |
| apb_ready | input | 1 | APB slave ready |

## Verification
The assertions assume that the requester obeys the ready handshake. They also assume that `apb_ready` is only meaningful in the access phase, so a high level at any other time must not start or end anything. The bench drives all inputs on the falling edge and keeps `wr_datum` valid only in the data-phase cycle, changing it right after that cycle. It raises `apb_ready` only while an access phase is under way. Requests made while the block is busy are deliberately placed in the setup and access cycles and removed before completion, so that none of them is taken in the ready cycle that follows.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

  localparam int SIZE_W = 3;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd0;
  localparam logic [SIZE_W-1:0] SZ_HALF = 3'd1;
  localparam logic [SIZE_W-1:0] SZ_WORD = 3'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_SETUP  = 2'd2,
    ST_ACCESS = 2'd3
  } nwb_state_e;

endpackage

// File: rtl/nwb_addr_cap.sv
module nwb_addr_cap
  import nwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [SIZE_W-1:0] size_in,
  output logic [ADDR_W-1:0] word_addr_q,
  output logic [SIZE_W-1:0] size_q
);

  localparam int LANES   = DATA_W / 8;
  localparam int ALIGN_W = $clog2(LANES);

  // Round a byte address down to the start of its bus word.
  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[ALIGN_W-1:0] = '0;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr_q <= '0;
      size_q      <= SZ_WORD;
    end else if (load) begin
      word_addr_q <= align_down(addr_in);
      size_q      <= size_in;
    end
  end

endmodule

// File: rtl/nwb_lane_rep.sv
module nwb_lane_rep
  import nwb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [DATA_W-1:0] datum_in,
  output logic [DATA_W-1:0] rep_q
);

  localparam int LANES   = DATA_W / 8;
  localparam int LOG2_LN = $clog2(LANES);

  // Number of bytes that one transfer unit spans, clamped to the bus width.
  function automatic int unit_bytes(input logic [SIZE_W-1:0] sz);
    if (int'(sz) >= LOG2_LN) return LANES;
    return 1 << sz;
  endfunction

  // Each lane takes the byte of the datum at its offset within the unit.
  function automatic logic [DATA_W-1:0] replicate(input logic [SIZE_W-1:0] sz,
                                                  input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    int unit;
    unit = unit_bytes(sz);
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      r[i*8 +: 8] = d[(i % unit)*8 +: 8];
    end
    return r;
  endfunction

  logic [DATA_W-1:0] rep_d;
  assign rep_d = replicate(size_in, datum_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else if (load) rep_q <= rep_d;
  end

endmodule

// File: rtl/nwb_apb_seq.sv
module nwb_apb_seq
  import nwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic apb_ready,
  output logic ahb_ready,
  output logic psel,
  output logic penable,
  output logic accept_evt,
  output logic sample_evt,
  output logic done_evt
);

  nwb_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_evt = 1'b0;
    sample_evt = 1'b0;
    done_evt   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_req) begin
          accept_evt = 1'b1;
          state_d    = ST_DATA;
        end
      end
      ST_DATA: begin
        sample_evt = 1'b1;
        state_d    = ST_SETUP;
      end
      ST_SETUP: state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (apb_ready) begin
          done_evt = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ahb_ready = (state_q == ST_IDLE);
  assign psel      = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
  assign penable   = (state_q == ST_ACCESS);

endmodule

// File: rtl/narrow_wr_bridge.sv
module narrow_wr_bridge
  import nwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [2:0]            wr_size,
  input  logic [DATA_W-1:0]     wr_datum,
  output logic                  ahb_ready,
  output logic [DATA_W-1:0]     ahb_wdata,
  output logic [2:0]            ahb_size,
  output logic [ADDR_W-1:0]     apb_addr,
  output logic                  apb_sel,
  output logic                  apb_enable,
  output logic                  apb_write,
  output logic [DATA_W-1:0]     apb_wdata,
  output logic [DATA_W/8-1:0]   apb_strb,
  input  logic                  apb_ready
);

  localparam int LANES = DATA_W / 8;

  // Named internal events, brought out for the checker.
  logic accept_evt;
  logic sample_evt;
  logic done_evt;

  logic [ADDR_W-1:0] word_addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] rep_q;

  nwb_apb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .apb_ready  (apb_ready),
    .ahb_ready  (ahb_ready),
    .psel       (apb_sel),
    .penable    (apb_enable),
    .accept_evt (accept_evt),
    .sample_evt (sample_evt),
    .done_evt   (done_evt)
  );

  nwb_addr_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept_evt),
    .addr_in     (wr_addr),
    .size_in     (wr_size),
    .word_addr_q (word_addr_q),
    .size_q      (size_q)
  );

  nwb_lane_rep #(.DATA_W(DATA_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sample_evt),
    .size_in  (size_q),
    .datum_in (wr_datum),
    .rep_q    (rep_q)
  );

  assign ahb_wdata = rep_q;
  assign ahb_size  = size_q;
  assign apb_addr  = word_addr_q;
  assign apb_wdata = rep_q;
  assign apb_write = apb_sel;
  assign apb_strb  = {LANES{apb_sel}};

endmodule

// File: rtl/nwb_checker.sv
module nwb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ahb_ready,
  input logic                psel,
  input logic                penable,
  input logic                pready,
  input logic                pwrite,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W/8-1:0] pstrb,
  input logic [2:0]          ahb_size,
  input logic                accept_evt,
  input logic                sample_evt,
  input logic                done_evt
);

  localparam int LANES   = DATA_W / 8;
  localparam int ALIGN_W = $clog2(LANES);

  assert_byte_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && ahb_size == 3'd0) |-> pwdata == {LANES{pwdata[7:0]}});

  assert_half_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && ahb_size == 3'd1) |-> pwdata == {(LANES/2){pwdata[15:0]}});

  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> paddr[ALIGN_W-1:0] == '0);

  assert_full_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> (pwrite && pstrb == {LANES{1'b1}}));

  assert_accept_then_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> sample_evt);

  assert_sample_then_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> (psel && !penable));

  assert_setup_then_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  assert_access_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwdata)));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> !ahb_ready);

  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (ahb_ready && !psel));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> $past(ahb_ready) || ahb_ready);

endmodule

bind narrow_wr_bridge nwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ahb_ready  (ahb_ready),
  .psel       (apb_sel),
  .penable    (apb_enable),
  .pready     (apb_ready),
  .pwrite     (apb_write),
  .paddr      (apb_addr),
  .pwdata     (apb_wdata),
  .pstrb      (apb_strb),
  .ahb_size   (ahb_size),
  .accept_evt (accept_evt),
  .sample_evt (sample_evt),
  .done_evt   (done_evt)
);

// File: tb/sim_narrow_wr_bridge.sv
module sim_narrow_wr_bridge;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_req;
  logic [31:0] wr_addr;
  logic [2:0]  wr_size;
  logic [31:0] wr_datum;
  logic        ahb_ready;
  logic [31:0] ahb_wdata;
  logic [2:0]  ahb_size;
  logic [31:0] apb_addr;
  logic        apb_sel;
  logic        apb_enable;
  logic        apb_write;
  logic [31:0] apb_wdata;
  logic [3:0]  apb_strb;
  logic        apb_ready;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  narrow_wr_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_datum(wr_datum), .ahb_ready(ahb_ready),
    .ahb_wdata(ahb_wdata), .ahb_size(ahb_size), .apb_addr(apb_addr),
    .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
    .apb_wdata(apb_wdata), .apb_strb(apb_strb), .apb_ready(apb_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected bus word, by multiplication rather than by lane copying.
  function automatic logic [31:0] exp_word(input logic [2:0] sz, input logic [31:0] d);
    if (sz == 3'd0) return {24'd0, d[7:0]} * 32'h0101_0101;
    if (sz == 3'd1) return {16'd0, d[15:0]} * 32'h0001_0001;
    return d;
  endfunction

  task automatic do_write(input logic [31:0] addr, input logic [2:0] sz,
                          input logic [31:0] d, input int nwait, input bit poke);
    string rt;
    logic [31:0] ew;
    rt = (sz == 3'd0) ? "R2" : (sz == 3'd1) ? "R3" : "R4";
    ew = exp_word(sz, d);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = addr; wr_size = sz; wr_datum = 32'hDEAD_0000 ^ addr;
    chk("R7 ready before accept", {31'd0, ahb_ready}, 32'd1);
    @(negedge clk);
    wr_req = poke;
    if (poke) begin wr_addr = ~addr; wr_size = ~sz; end
    wr_datum = d;
    chk("R7 data phase ready low", {31'd0, ahb_ready}, 32'd0);
    chk("R7 data phase no select", {31'd0, apb_sel}, 32'd0);
    @(negedge clk);
    wr_datum = ~d;
    chk("R7 setup select/enable", {30'd0, apb_sel, apb_enable}, 32'd2);
    chk("R5 word address", apb_addr, {addr[31:2], 2'b00});
    chk({rt, " apb data"}, apb_wdata, ew);
    chk({rt, " ahb data"}, ahb_wdata, ew);
    chk({rt, " size code"}, {29'd0, ahb_size}, {29'd0, sz});
    chk("R6 strobes and write", {27'd0, apb_write, apb_strb}, 32'h1F);
    chk("R8 busy ready low", {31'd0, ahb_ready}, 32'd0);
    @(negedge clk);
    chk("R7 access select/enable", {30'd0, apb_sel, apb_enable}, 32'd3);
    for (int k = 0; k < nwait; k++) begin
      @(negedge clk);
      chk("R8 access held", {30'd0, apb_sel, apb_enable}, 32'd3);
      chk("R8 address stable", apb_addr, {addr[31:2], 2'b00});
      chk("R8 data stable", apb_wdata, ew);
      chk("R8 ready held low", {31'd0, ahb_ready}, 32'd0);
    end
    if (poke) begin
      chk("R9 captured address kept", apb_addr, {addr[31:2], 2'b00});
      chk("R9 captured size kept", {29'd0, ahb_size}, {29'd0, sz});
    end
    wr_req = 1'b0;
    apb_ready = 1'b1;
    @(negedge clk);
    apb_ready = 1'b0;
    chk("R8 release ready", {31'd0, ahb_ready}, 32'd1);
    chk("R8 release select", {31'd0, apb_sel}, 32'd0);
    if (poke) begin
      @(negedge clk);
      chk("R9 no extra transfer", {30'd0, apb_sel, ahb_ready}, 32'd1);
      @(negedge clk);
      chk("R9 no extra transfer later", {30'd0, apb_sel, ahb_ready}, 32'd1);
    end
  endtask

  initial begin
    logic [31:0] pat [3];
    pat[0] = 32'h1234_56AB;
    pat[1] = 32'hFEDC_B1B0;
    pat[2] = 32'h0F0F_8001;
    rst_n = 1'b0; wr_req = 1'b0; wr_addr = '0; wr_size = '0; wr_datum = '0;
    apb_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, ahb_ready}, 32'd1);
    chk("R1 reset select/enable", {30'd0, apb_sel, apb_enable}, 32'd0);
    chk("R1 reset strobes", {28'd0, apb_strb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset idle", {29'd0, ahb_ready, apb_sel, apb_enable}, 32'd4);
    for (int sz = 0; sz < 8; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int p = 0; p < 3; p++) begin
          do_write(32'h4000_1000 + 32'(p) * 32'h100 + 32'(lo), 3'(sz),
                   pat[p] ^ 32'(sz * 32'h0011_0000), (lo + p) % 3,
                   1'((sz + lo) % 2));
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule